// File: doc/BRIEF.md
# Per-Connection Register Access Guard

This block sits between a memory-mapped register bus and a small bank of per-connection registers. Every connection owns a page-sized address region of its own, and every register in that region is reachable through two aliases: a privileged (kernel) alias and an unprivileged (user) alias. The two aliases differ in one address bit. Both aliases reach the same physical storage.

Each connection has a permission word with one bit for each data register. The privileged alias may always read and write everything, the permission word included. The unprivileged alias may always read. It may write a data register only when that register's permission bit is set. A user write that is refused is dropped, and a one-cycle violation pulse is raised. The permission word itself is guarded by a bit that is wired to zero, so it can never be written through the user alias. Read data returns one cycle after the request.

Top module: `reg_access_guard`

## Requirements
- R1: The address is split into three fields. The top bit `req_addr[ADDR_W-1]` is the alias: 0 selects the kernel alias and 1 selects the user alias. The next CONN_W bits, `req_addr[PAGE_W +: CONN_W]`, give the connection index. The low PAGE_W bits give the word offset inside the connection's page. Offsets 0..NUM_REGS-1 are the data registers, and offset NUM_REGS is the permission word. With the defaults (4 connections, 4 registers, PAGE_W=4) the address is 7 bits wide.
- R2: A kernel-alias write to any data register or to the permission word always takes effect. Only bits 0..NUM_REGS-1 of the permission word are stored. A kernel-alias write never raises the violation output.
- R3: Both aliases reach the same storage. A read through either alias returns the value last written, whatever the permission bits are.
- R4: A user-alias write to data register k takes effect when bit k of that connection's permission word is 1.
- R5: A user-alias write to data register k is dropped when bit k of the permission word is 0. The register keeps its old value.
- R6: A dropped user write drives `access_violation` high for exactly the one cycle after the request. The output is low in every other cycle.
- R7: The permission word is read-only at the user alias. A user write to it is always dropped and always raises the violation pulse.
- R8: A read request returns `rsp_valid` high with `rsp_rdata` in the following cycle. `rsp_valid` is low after a write request or an idle cycle. The permission word reads back zero-extended.
- R9: Reset clears every data register and every permission word. After reset all registers read zero, and every register is read-only for users.
- R10: A write changes only the addressed register of the addressed connection.
- R11: An offset above NUM_REGS inside a page is unmapped. A read of it returns zero. A write to it is dropped without a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Alias, connection and offset fields |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| access_violation | output | 1 | One-cycle pulse after a dropped user write |

## Verification
Directed sequences first check the cleared state. They then grant a single permission bit and write through the user alias to a register with the bit set and to one with the bit clear. This separates the gating from a plain alias decode. User writes to the permission word and to unmapped offsets tell the guarded-by-zero bit apart from the silent unmapped path. Writes aimed at one connection are followed by reads of a neighbour, which exposes any leak between banks. Seeded random traffic then mixes aliases, offsets and permission values, and compares every read and every violation cycle against a reference model kept in the bench.

// File: rtl/ag_pkg.sv
package ag_pkg;

   typedef enum logic {
      ALIAS_KERNEL = 1'b0,
      ALIAS_USER   = 1'b1
   } alias_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ag_addr_decode.sv
module ag_addr_decode
   import ag_pkg::*;
#(
   parameter int NUM_CONN = 4,
   parameter int NUM_REGS = 4,
   parameter int PAGE_W   = 4,
   parameter int CONN_W   = 2,
   parameter int GIDX_W   = 3,
   parameter int ADDR_W   = 1 + CONN_W + PAGE_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   output alias_e            alias_o,
   output logic [CONN_W-1:0] conn_o,
   output logic [GIDX_W-1:0] gidx_o,
   output logic              conn_hit_o,
   output logic              is_data_o,
   output logic              is_mask_o
);

   logic [PAGE_W-1:0] offset;

   assign alias_o = alias_e'(addr_i[ADDR_W-1]);
   assign conn_o  = addr_i[PAGE_W +: CONN_W];
   assign offset  = addr_i[PAGE_W-1:0];
   assign gidx_o  = offset[GIDX_W-1:0];

   assign is_data_o = (offset < PAGE_W'(NUM_REGS));
   assign is_mask_o = (offset == PAGE_W'(NUM_REGS));

   generate
      if ((2 ** CONN_W) == NUM_CONN) begin : g_full_conn
         assign conn_hit_o = 1'b1;
      end else begin : g_partial_conn
         assign conn_hit_o = (conn_o < CONN_W'(NUM_CONN));
      end
   endgenerate

endmodule

// File: rtl/ag_permit.sv
module ag_permit
   import ag_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int GIDX_W   = 3
) (
   input  logic                valid_i,
   input  logic                write_i,
   input  alias_e              alias_i,
   input  logic                conn_hit_i,
   input  logic                is_data_i,
   input  logic                is_mask_i,
   input  logic [GIDX_W-1:0]   gidx_i,
   input  logic [NUM_REGS-1:0] mask_i,
   output logic                grant_o,
   output logic                deny_o
);

   // Guard bit NUM_REGS protects the permission word itself and is tied low.
   logic [NUM_REGS:0] guard;
   logic              guard_sel;
   logic              mapped_wr;

   assign guard     = {1'b0, mask_i};
   assign guard_sel = guard[gidx_i];
   assign mapped_wr = valid_i & write_i & conn_hit_i & (is_data_i | is_mask_i);

   always_comb begin
      grant_o = 1'b0;
      deny_o  = 1'b0;
      if (mapped_wr) begin
         if (alias_i == ALIAS_KERNEL || guard_sel) grant_o = 1'b1;
         else                                     deny_o  = 1'b1;
      end
   end

endmodule

// File: rtl/ag_conn_bank.sv
module ag_conn_bank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 16,
   parameter int GIDX_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic                is_data_i,
   input  logic                is_mask_i,
   input  logic [GIDX_W-1:0]   gidx_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic [NUM_REGS-1:0] mask_o
);

   logic [DATA_W-1:0]   regs_q [NUM_REGS];
   logic [NUM_REGS-1:0] mask_q;

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_q[g] <= '0;
            else if (we_i && is_data_i && gidx_i == GIDX_W'(g))
               regs_q[g] <= wdata_i;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (we_i && is_mask_i)
         mask_q <= wdata_i[NUM_REGS-1:0];
   end

   always_comb begin
      rdata_o = '0;
      if (is_mask_i)
         rdata_o = DATA_W'(mask_q);
      else if (is_data_i)
         rdata_o = regs_q[gidx_i];
   end

   assign mask_o = mask_q;

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(mask_q));

endmodule

// File: rtl/reg_access_guard.sv
module reg_access_guard
   import ag_pkg::*;
#(
   parameter int NUM_CONN = 4,
   parameter int NUM_REGS = 4,
   parameter int PAGE_W   = 4,
   parameter int DATA_W   = 16,
   localparam int CONN_W  = idx_width(NUM_CONN),
   localparam int ADDR_W  = 1 + CONN_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              access_violation
);

   localparam int GIDX_W = idx_width(NUM_REGS + 1);

   generate
      if (NUM_CONN < 2)             begin : g_bad_conn  $error("NUM_CONN must be at least 2"); end
      if (NUM_REGS < 1)             begin : g_bad_regs  $error("NUM_REGS must be at least 1"); end
      if (NUM_REGS + 1 > 2**PAGE_W) begin : g_bad_page  $error("page too small for registers"); end
      if (DATA_W < NUM_REGS)        begin : g_bad_width $error("DATA_W narrower than mask"); end
      if (GIDX_W > PAGE_W)          begin : g_bad_gidx  $error("PAGE_W too small"); end
   endgenerate

   alias_e              dec_alias;
   logic [CONN_W-1:0]   dec_conn;
   logic [GIDX_W-1:0]   dec_gidx;
   logic                dec_hit, dec_data, dec_mask;
   logic                wr_grant, wr_deny;
   logic [NUM_CONN-1:0] bank_we;
   logic [DATA_W-1:0]   bank_rdata [NUM_CONN];
   logic [NUM_REGS-1:0] bank_mask  [NUM_CONN];
   logic [NUM_REGS-1:0] sel_mask;
   logic [DATA_W-1:0]   sel_rdata;

   ag_addr_decode #(
      .NUM_CONN (NUM_CONN), .NUM_REGS (NUM_REGS), .PAGE_W (PAGE_W),
      .CONN_W   (CONN_W),   .GIDX_W   (GIDX_W),   .ADDR_W (ADDR_W)
   ) u_decode (
      .addr_i     (req_addr),
      .alias_o    (dec_alias),
      .conn_o     (dec_conn),
      .gidx_o     (dec_gidx),
      .conn_hit_o (dec_hit),
      .is_data_o  (dec_data),
      .is_mask_o  (dec_mask)
   );

   assign sel_mask  = dec_hit ? bank_mask[dec_conn]  : '0;
   assign sel_rdata = dec_hit ? bank_rdata[dec_conn] : '0;

   ag_permit #(.NUM_REGS (NUM_REGS), .GIDX_W (GIDX_W)) u_permit (
      .valid_i    (req_valid),
      .write_i    (req_write),
      .alias_i    (dec_alias),
      .conn_hit_i (dec_hit),
      .is_data_i  (dec_data),
      .is_mask_i  (dec_mask),
      .gidx_i     (dec_gidx),
      .mask_i     (sel_mask),
      .grant_o    (wr_grant),
      .deny_o     (wr_deny)
   );

   genvar c;
   generate
      for (c = 0; c < NUM_CONN; c++) begin : g_conn
         assign bank_we[c] = wr_grant && (dec_conn == CONN_W'(c));

         ag_conn_bank #(.NUM_REGS (NUM_REGS), .DATA_W (DATA_W), .GIDX_W (GIDX_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (bank_we[c]),
            .is_data_i (dec_data),
            .is_mask_i (dec_mask),
            .gidx_i    (dec_gidx),
            .wdata_i   (req_wdata),
            .rdata_o   (bank_rdata[c]),
            .mask_o    (bank_mask[c])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid        <= 1'b0;
         rsp_rdata        <= '0;
         access_violation <= 1'b0;
      end else begin
         rsp_valid        <= req_valid & ~req_write;
         rsp_rdata        <= (req_valid & ~req_write) ? sel_rdata : '0;
         access_violation <= wr_deny;
      end
   end

   // R6
   deny_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_violation |-> $past(req_valid && req_write && req_addr[ADDR_W-1]));

   // R2
   kernel_never_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_addr[ADDR_W-1]) |=> !access_violation);

   // R7
   mask_user_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && dec_alias == ALIAS_USER && dec_mask && dec_hit)
         |=> access_violation);

   // R8
   rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   // R8
   read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   // R10
   single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

endmodule

// File: tb/tb_reg_access_guard.sv
module tb_reg_access_guard;

   localparam int NUM_CONN = 4;
   localparam int NUM_REGS = 4;
   localparam int PAGE_W   = 4;
   localparam int DATA_W   = 16;
   localparam int CONN_W   = 2;
   localparam int ADDR_W   = 1 + CONN_W + PAGE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic              access_violation;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0]   m_regs [NUM_CONN][NUM_REGS];
   logic [NUM_REGS-1:0] m_mask [NUM_CONN];

   always #10 clk = ~clk;

   reg_access_guard #(
      .NUM_CONN (NUM_CONN), .NUM_REGS (NUM_REGS), .PAGE_W (PAGE_W), .DATA_W (DATA_W)
   ) dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata), .access_violation (access_violation)
   );

   function automatic logic [ADDR_W-1:0] mk_addr(input bit usr, input int conn, input int off);
      return {usr, CONN_W'(conn), PAGE_W'(off)};
   endfunction

   function automatic logic [DATA_W-1:0] model_read(input int conn, input int off);
      if (off < NUM_REGS)       return m_regs[conn][off];
      else if (off == NUM_REGS) return DATA_W'(m_mask[conn]);
      return '0;
   endfunction

   // returns 1 if the write must be refused with a violation
   function automatic bit model_write(input bit usr, input int conn, input int off,
                                      input logic [DATA_W-1:0] d);
      if (off < NUM_REGS) begin
         if (!usr || m_mask[conn][off]) begin m_regs[conn][off] = d; return 0; end
         return 1;
      end else if (off == NUM_REGS) begin
         if (!usr) begin m_mask[conn] = d[NUM_REGS-1:0]; return 0; end
         return 1;
      end
      return 0;
   endfunction

   task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drives at negedge, samples at the following negedge.
   task automatic access(input string req, input bit usr, input int conn, input int off,
                         input bit wr, input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] exp_rd;
      bit                exp_den;
      exp_rd  = model_read(conn, off);
      exp_den = wr ? model_write(usr, conn, off, d) : 1'b0;
      req_valid = 1'b1; req_write = wr; req_addr = mk_addr(usr, conn, off); req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check(req, "rsp_valid", DATA_W'(rsp_valid), DATA_W'(!wr));
      check(req, "violation", DATA_W'(access_violation), DATA_W'(exp_den));
      if (!wr) check(req, "rdata", rsp_rdata, exp_rd);
   endtask

   task automatic idle_check(input string req);
      @(posedge clk);
      @(negedge clk);
      check(req, "idle violation", DATA_W'(access_violation), '0);
      check(req, "idle rsp_valid", DATA_W'(rsp_valid), '0);
   endtask

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NUM_CONN; c++) begin
         m_mask[c] = '0;
         for (int r = 0; r < NUM_REGS; r++) m_regs[c][r] = '0;
      end
      repeat (3) @(negedge clk);
      check("R9", "violation in reset", DATA_W'(access_violation), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: all cleared, through both aliases
      for (int c = 0; c < NUM_CONN; c++)
         for (int o = 0; o <= NUM_REGS; o++) access("R9", 1'b1, c, o, 1'b0, '0);

      // R9/R5: default read-only for users
      access("R5", 1'b1, 1, 2, 1'b1, 16'hBEEF);
      idle_check("R6");
      access("R5", 1'b0, 1, 2, 1'b0, '0);

      // R2/R3: kernel writes, user reads same storage
      access("R2", 1'b0, 2, 0, 1'b1, 16'h1234);
      access("R3", 1'b1, 2, 0, 1'b0, '0);
      access("R2", 1'b0, 2, NUM_REGS, 1'b1, 16'hFFF5);
      access("R8", 1'b1, 2, NUM_REGS, 1'b0, '0);

      // R4/R5: mask 0101 for conn 2
      access("R4", 1'b1, 2, 0, 1'b1, 16'hA0A0);
      access("R4", 1'b0, 2, 0, 1'b0, '0);
      access("R4", 1'b1, 2, 2, 1'b1, 16'hC3C3);
      access("R5", 1'b1, 2, 1, 1'b1, 16'h5555);
      idle_check("R6");
      access("R5", 1'b1, 2, 1, 1'b0, '0);

      // R7: permission word never writable at user alias
      access("R7", 1'b1, 2, NUM_REGS, 1'b1, 16'h000F);
      access("R7", 1'b0, 2, NUM_REGS, 1'b0, '0);

      // R11: unmapped offsets
      access("R11", 1'b0, 3, NUM_REGS + 1, 1'b1, 16'h7777);
      access("R11", 1'b1, 3, 15, 1'b1, 16'h7777);
      access("R11", 1'b0, 3, NUM_REGS + 1, 1'b0, '0);

      // R10: neighbours untouched
      access("R10", 1'b0, 0, 3, 1'b1, 16'h9999);
      for (int c = 1; c < NUM_CONN; c++) access("R10", 1'b0, c, 3, 1'b0, '0);

      // Random traffic against the model (R1..R11)
      for (int i = 0; i < 600; i++) begin
         bit usr, wr;
         int conn, off;
         logic [DATA_W-1:0] d;
         usr  = 1'($urandom);
         wr   = 1'($urandom);
         conn = int'($urandom_range(0, NUM_CONN - 1));
         off  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 15))
                                            : int'($urandom_range(0, NUM_REGS));
         d    = DATA_W'($urandom);
         access("R1", usr, conn, off, wr, d);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule